// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures the frequency of an intermediate-frequency signal. It counts the rising edges of a squared pulse input during a gate window of known length. Software first writes a 4-bit control word. The upper two bits pick the measurement mode, and the lower two pick the gate length. A separate start pulse then clears the count and opens the gate. When the gate closes, a done flag rises and the count is held for software to read. The pulse rate is the count divided by the gate time.

The gate is timed in cycles of the system clock. One millisecond is `TICKS_PER_MS` cycles, which defaults to 75 for a 75 kHz clock. The pulse input goes through a two-flop synchronizer and a rising-edge detector, so each high and each low phase of the input must last at least two clock cycles. A low-power input forces the pulse input to zero. It is meant to be held high whenever the surrounding chip is in a backup, halt or synthesizer-stop state.

Top module: `freq_gate_counter`

## Requirements
- R1: After reset, `count` is 0, `done` is 0, the gate is closed and the stored control word is 4'b0000.
- R2: A cycle with `ctl_wr` high stores `ctl_word`. Bits [3:2] are the mode, where 2'b00 means frequency measurement. Bits [1:0] select the gate: 2'b00 is 1 ms, 2'b01 is 4 ms, 2'b10 is 8 ms and 2'b11 is 32 ms. One ms is `TICKS_PER_MS` clock cycles.
- R3: A `start` pulse taken while the mode is 2'b00 sets `count` to 0 and `done` to 0 at the next edge, and opens the gate. `done` rises exactly N edges after that, where N is the selected gate length in cycles.
- R4: A `start` pulse taken while the mode is not 2'b00 has no effect: `count` and `done` keep their values.
- R5: At gate close, `count` equals the number of rising edges of `if_in` that occurred inside the gate.
- R6: While the gate is closed, `count` and `done` hold their values until the next accepted start, whatever `if_in` does.
- R7: `count` saturates at its all-ones value and never wraps.
- R8: An accepted `start` while the gate is open restarts the measurement. It clears `count` and `done` and reloads the full gate length.
- R9: While `lowpwr` is high, `if_in` is treated as 0, and pulses on it are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lowpwr | input | 1 | Forces the pulse input off while high |
| if_in | input | 1 | Squared IF pulse input (asynchronous) |
| ctl_wr | input | 1 | Stores `ctl_word` when high |
| ctl_word | input | 4 | Mode [3:2] and gate select [1:0] |
| start | input | 1 | Start command |
| count | output | COUNT_W | Edge count of the last or current gate |
| done | output | 1 | High once the gate has closed |

## Verification
The bench sweeps all four gate selections and checks `done` every cycle of the window. A timer off by one, or with the wrong length table, shows up as an early or late flag. It restarts a measurement part-way through a gate: a design that failed to reload the timer would raise `done` too early, and one that failed to clear would carry stale edges into the result. It also pulses the input while the gate is closed, while the mode is not 2'b00 and while `lowpwr` is high, where any counting would inflate the value. Finally, a narrow 4-bit instance receives more edges than it can hold, so a wrapping counter reads a small value instead of 15.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        GATE_1MS  = 2'b00,
        GATE_4MS  = 2'b01,
        GATE_8MS  = 2'b10,
        GATE_32MS = 2'b11
    } gate_sel_e;

    typedef enum logic [1:0] {
        MODE_FREQ  = 2'b00,
        MODE_RSV1  = 2'b01,
        MODE_RSV2  = 2'b10,
        MODE_RSV3  = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e     mode;
        gate_sel_e gate;
    } ctl_word_t;

    localparam int unsigned LONGEST_GATE_MS = 32;

    function automatic int unsigned gate_ms(gate_sel_e sel);
        case (sel)
            GATE_1MS:  return 1;
            GATE_4MS:  return 4;
            GATE_8MS:  return 8;
            default:   return LONGEST_GATE_MS;
        endcase
    endfunction

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic enable,
    output logic rise
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-1:0], din & enable};
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
    parameter int TMR_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] len,
    output logic             open,
    output logic             expire
);
    logic [TMR_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)              remain <= '0;
        else if (load)        remain <= len;
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign open   = (remain != '0);
    assign expire = (remain == TMR_W'(1)) && !load;
endmodule

// File: rtl/ifc_event_counter.sv
module ifc_event_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clear)              value <= '0;
        else if (inc && value != TOP)  value <= value + 1'b1;
    end
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter
    import ifc_pkg::*;
#(
    parameter int COUNT_W      = 20,
    parameter int TICKS_PER_MS = 75,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lowpwr,
    input  logic               if_in,
    input  logic               ctl_wr,
    input  logic [3:0]         ctl_word,
    input  logic               start,
    output logic [COUNT_W-1:0] count,
    output logic               done
);
    localparam int MAX_GATE = LONGEST_GATE_MS * TICKS_PER_MS;
    localparam int TMR_W    = $clog2(MAX_GATE + 1);

    ctl_word_t        ctl_q;
    logic             launch;
    logic             gate_open;
    logic             gate_expire;
    logic             pulse_rise;
    logic [TMR_W-1:0] gate_len;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_word_t'(ctl_word);
    end

    assign launch   = start && (ctl_q.mode == MODE_FREQ);
    assign gate_len = TMR_W'(gate_ms(ctl_q.gate) * TICKS_PER_MS);

    ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (if_in),
        .enable (!lowpwr),
        .rise   (pulse_rise)
    );

    ifc_gate_timer #(.TMR_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (launch),
        .len    (gate_len),
        .open   (gate_open),
        .expire (gate_expire)
    );

    ifc_event_counter #(.W(COUNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .clear (launch),
        .inc   (pulse_rise && gate_open),
        .value (count)
    );

    always_ff @(posedge clk) begin
        if (rst || launch)    done <= 1'b0;
        else if (gate_expire) done <= 1'b1;
    end
endmodule

// File: rtl/freq_gate_counter_chk.sv
module freq_gate_counter_chk #(
    parameter int COUNT_W = 20
) (
    input logic               clk,
    input logic               rst,
    input logic               launch,
    input logic               gate_open,
    input logic [COUNT_W-1:0] count,
    input logic               done
);
    localparam logic [COUNT_W-1:0] TOP = '1;

    assert_launch_clears_R3: assert property (@(posedge clk) disable iff (rst)
        launch |=> (count == '0 && !done && gate_open));

    // R3: done may only rise on the edge where the gate shuts
    assert_done_at_close_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $fell(gate_open));

    assert_hold_closed_R6: assert property (@(posedge clk) disable iff (rst)
        (!gate_open && !launch) |=> ($stable(count) && $stable(done)));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (gate_open && !launch) |=> (count >= $past(count)));

    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (count == TOP && !launch) |=> (count == TOP));
endmodule

bind freq_gate_counter freq_gate_counter_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .gate_open (gate_open),
    .count     (count),
    .done      (done)
);

// File: tb/freq_gate_counter_test.sv
module freq_gate_counter_test;
    localparam int TPM = 75;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lowpwr = 1'b0;
    logic        if_in = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [3:0]  ctl_word = 4'h0;
    logic        start = 1'b0;
    logic [19:0] count;
    logic        done;
    logic [3:0]  n_count;
    logic        n_done;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    freq_gate_counter uut (
        .clk(clk), .rst(rst), .lowpwr(lowpwr), .if_in(if_in),
        .ctl_wr(ctl_wr), .ctl_word(ctl_word), .start(start),
        .count(count), .done(done)
    );

    freq_gate_counter #(.COUNT_W(4), .TICKS_PER_MS(8)) uut_narrow (
        .clk(clk), .rst(rst), .lowpwr(lowpwr), .if_in(if_in),
        .ctl_wr(ctl_wr), .ctl_word(ctl_word), .start(start),
        .count(n_count), .done(n_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pulse_at(input int i, input int h, input int np);
        return (i >= 4) && (i < 4 + 2*h*np) && (((i - 4) / h) % 2 == 0);
    endfunction

    task automatic write_ctl(input logic [3:0] w);
        @(negedge clk); ctl_wr = 1'b1; ctl_word = w;
        @(posedge clk); #1 ctl_wr = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run_pulses(input int ncyc, input int h, input int np);
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk); if_in = pulse_at(i, h, np);
            @(posedge clk);
        end
        @(negedge clk); if_in = 1'b0;
    endtask

    // Gate window of len cycles after start; done must stay low until edge len
    task automatic measure(input int len, input int h, input int np, input string req);
        int early = 0;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if_in = pulse_at(i, h, np);
            if (done) early++;
            @(posedge clk);
        end
        #1;
        check(early == 0 && done, {req, " done timing"}, early, 0);
        check(count == 20'(np), {req, " count"}, int'(count), np);
        if_in = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check(count == 0, "R1 count", int'(count), 0);
        check(done == 0, "R1 done", int'(done), 0);
        do_start();   // stored control word 0000 => 1 ms gate accepted
        measure(TPM, 4, 3, "R1 default word");

        // R2 R3 R5 sweep of all gate selections
        for (int s = 0; s < 4; s++) begin
            int ms_tab [4] = '{1, 4, 8, 32};
            write_ctl(4'(s));
            do_start();
            check(count == 0 && done == 0, "R3 clear at start", int'(count), 0);
            measure(ms_tab[s] * TPM, 4, 5 + 7*s, "R2 R3 R5 sweep");
        end

        // R6 hold while closed
        run_pulses(30, 3, 4);
        check(count == 26 && done, "R6 hold count", int'(count), 26);

        // R4 non-frequency modes ignored
        for (int m = 1; m < 4; m++) begin
            write_ctl({2'(m), 2'b00});
            do_start();
            run_pulses(20, 3, 2);
            check(count == 26 && done, "R4 ignored start", int'(count), 26);
        end

        // R8 restart during an open gate
        write_ctl(4'b0000);
        do_start();
        run_pulses(30, 4, 3);
        do_start();
        check(count == 0 && done == 0, "R8 restart clear", int'(count), 0);
        measure(TPM, 4, 2, "R8 restart reload");

        // R9 pulses ignored under low power
        do_start();
        lowpwr = 1'b1;
        run_pulses(40, 4, 4);
        lowpwr = 1'b0;
        run_pulses(20, 4, 2);
        for (int k = 0; k < 40 && !done; k++) @(posedge clk);
        #1;
        check(done && count == 2, "R9 low power", int'(count), 2);

        // R7 saturation on the narrow instance (32 ms * 8 = 256 cycles)
        write_ctl(4'b0011);
        do_start();
        run_pulses(200, 4, 20);
        for (int k = 0; k < 100 && !n_done; k++) @(posedge clk);
        #1;
        check(n_done && n_count == 4'hF, "R7 saturate", int'(n_count), 15);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule